// File: doc/BRIEF.md
# Split-Sub-Bank Compressed Word Store

This block holds the data words of a small set-associative cache. Each 32-bit word is split across two separately enabled sub-banks. The narrow sub-bank holds a compressed flag and a short dictionary code. The wide sub-bank holds the remaining upper bits of a word that is stored uncompressed. On a read, the narrow sub-bank of every way in the addressed set is enabled at once, in the same cycle as the external tag lookup. A compressed word is decoded through an external dictionary port and returned one cycle after the request. An uncompressed word costs a second cycle. In that cycle only the hit way's wide sub-bank is enabled. A miss never touches the wide sub-banks.

Writes carry either a dictionary code or a full value. A compressed write touches only the narrow sub-bank of the hit way. A per-way enable pulse on each sub-bank lets the surrounding logic count the energy spent. A global switch turns compression off. While it is off, every access opens both sub-banks and the flag has no meaning. Tag storage, tag comparison and the dictionary contents are outside the block.

Top module: `sbWordArray`

## Requirements
- R1: After reset `busy`, `rdValid` and both enable vectors are low, and every stored word reads as an uncompressed zero (flag 0, code 0, upper bits 0).
- R2: The narrow sub-bank entry is {flag, code}, with the flag above a code of CODE_W = log2(DICT_ENTRIES) bits. A write that hits with a full value stores bits [CODE_W-1:0] in the code field and bits [31:CODE_W] in the wide sub-bank, and clears the flag. In its request cycle it raises `narrowEn` and `wideEn` for the hit way only.
- R3: With compression on, a read hit on a word whose flag is set does the following. In the request cycle it raises `narrowEn` for all ways and no `wideEn`, and `dictCode` shows the stored code. `rdData` equals `dictValue` with `rdValid` high exactly one cycle after the request.
- R4: With compression on, a read hit on a word whose flag is clear raises `busy` in the next cycle. In that cycle `wideEn` is set for the hit way only and `narrowEn` is low. Two cycles after the request `rdValid` is high and `rdData` is {wide bits, code bits}.
- R5: A read miss with compression on raises `narrowEn` for all ways in the request cycle. It never raises `wideEn` and returns no data.
- R6: A compressed write hit with compression on raises only the hit way's `narrowEn`. It stores the code with the flag set, so a later read returns the dictionary value in one cycle.
- R7: A write miss raises no enable and leaves the stored word unchanged.
- R8: With compression off, a read raises both enables for all ways in the request cycle. A hit returns the raw {wide, code} one cycle later, whatever the flag. A write hit stores `wrData` in full with the flag clear, even when marked compressed.
- R9: A request presented while `busy` is high is ignored: it writes nothing and produces no data.
- R10: Latency depends only on the flag of the requested word. A compressed word returns in one cycle even when the other words of its line are uncompressed.
- R11: `rdValid` is a single pulse per read hit, and writes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| compEn | input | 1 | Compression enable |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSet | input | SET_W | Set index |
| reqWord | input | WORD_W | Word index within the line |
| reqHit | input | 1 | Tag lookup hit |
| reqHitWay | input | WAY_W | Way that hit |
| wrCompressed | input | 1 | Write carries a dictionary code |
| wrCode | input | CODE_W | Code for a compressed write |
| wrData | input | 32 | Full value for an uncompressed write |
| dictCode | output | CODE_W | Code of the requested word, to the dictionary |
| dictValue | input | 32 | Dictionary value for `dictCode` |
| busy | output | 1 | Second-cycle wide access in progress |
| rdValid | output | 1 | Read data valid pulse |
| rdData | output | 32 | Read data |
| narrowEn | output | NUM_WAYS | Narrow sub-bank enable per way |
| wideEn | output | NUM_WAYS | Wide sub-bank enable per way |

## Verification
The sub-bank enables and `dictCode` are combinational results of the request, so they are sampled in the request cycle itself. `busy` and the second-cycle `wideEn` are due one cycle later. `rdValid` is due one cycle after the request for compressed or compression-off reads and two cycles after for uncompressed reads. Each read pushes its expected value together with the cycle number in which it must appear. The monitor pops that entry on each `rdValid` and compares both the data and the arrival cycle. Any pulse that was not expected, including one caused by a write or by an ignored request, finds an empty queue and is reported.

// File: rtl/sbWordPkg.sv
package sbWordPkg;
  localparam int DATA_W = 32;

  // strobes from the sequencer to the storage datapath
  typedef struct packed {
    logic captureWide;   // hold pending word for a second-cycle wide read
    logic loadDecoded;   // output dictionary value
    logic loadDirect;    // output raw {wide, code} of current request
    logic loadPending;   // output raw {wide, code} of held request
    logic writeCode;     // store code with flag set
    logic writeFull;     // store full value with flag clear
  } sbStrobe_t;
endpackage

// File: rtl/sbCtrl.sv
module sbCtrl
  import sbWordPkg::*;
#(
  parameter int NUM_WAYS = 2,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                compEn,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqHit,
  input  logic [WAY_W-1:0]    reqHitWay,
  input  logic                wrCompressed,
  input  logic                hitFlag,
  output sbStrobe_t           strobe,
  output logic                busy,
  output logic [WAY_W-1:0]    pendWay,
  output logic [NUM_WAYS-1:0] narrowEn,
  output logic [NUM_WAYS-1:0] wideEn
);
  logic                busyQ;
  logic [WAY_W-1:0]    pendWayQ;
  logic [NUM_WAYS-1:0] hitDec;
  logic [NUM_WAYS-1:0] pendDec;
  logic                accept;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : gDec
    assign hitDec[g]  = (reqHitWay == WAY_W'(g));
    assign pendDec[g] = (pendWayQ == WAY_W'(g));
  end

  assign accept = reqValid && !busyQ;

  always_comb begin
    strobe   = '0;
    narrowEn = '0;
    wideEn   = '0;
    if (busyQ) begin
      wideEn             = pendDec;
      strobe.loadPending = 1'b1;
    end else if (accept) begin
      if (!reqWrite) begin
        narrowEn = '1;
        if (!compEn) begin
          wideEn            = '1;
          strobe.loadDirect = reqHit;
        end else if (reqHit) begin
          if (hitFlag) strobe.loadDecoded = 1'b1;
          else         strobe.captureWide = 1'b1;
        end
      end else if (reqHit) begin
        narrowEn = hitDec;
        if (compEn && wrCompressed) begin
          strobe.writeCode = 1'b1;
        end else begin
          wideEn           = hitDec;
          strobe.writeFull = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      pendWayQ <= '0;
    end else begin
      busyQ <= strobe.captureWide;
      if (strobe.captureWide) pendWayQ <= reqHitWay;
    end
  end

  assign busy    = busyQ;
  assign pendWay = pendWayQ;
endmodule

// File: rtl/sbDatapath.sv
module sbDatapath
  import sbWordPkg::*;
#(
  parameter int NUM_WAYS     = 2,
  parameter int NUM_SETS     = 4,
  parameter int LINE_WORDS   = 4,
  parameter int DICT_ENTRIES = 16,
  localparam int CODE_W   = $clog2(DICT_ENTRIES),
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WORD_W   = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int NARROW_W = CODE_W + 1,
  localparam int WIDE_W   = DATA_W - CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbStrobe_t         strobe,
  input  logic [SET_W-1:0]  reqSet,
  input  logic [WORD_W-1:0] reqWord,
  input  logic [WAY_W-1:0]  reqHitWay,
  input  logic [WAY_W-1:0]  pendWay,
  input  logic [CODE_W-1:0] wrCode,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] dictValue,
  output logic [CODE_W-1:0] dictCode,
  output logic              hitFlag,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  logic [NARROW_W-1:0] narrowMem [NUM_SETS][NUM_WAYS][LINE_WORDS];
  logic [WIDE_W-1:0]   wideMem   [NUM_SETS][NUM_WAYS][LINE_WORDS];

  logic [NARROW_W-1:0] hitNarrow;
  logic [WIDE_W-1:0]   hitWide;
  logic [WIDE_W-1:0]   pendWide;
  logic [SET_W-1:0]    pendSet;
  logic [WORD_W-1:0]   pendWord;
  logic [CODE_W-1:0]   pendCode;

  assign hitNarrow = narrowMem[reqSet][reqHitWay][reqWord];
  assign hitWide   = wideMem[reqSet][reqHitWay][reqWord];
  assign pendWide  = wideMem[pendSet][pendWay][pendWord];
  assign hitFlag   = hitNarrow[CODE_W];
  assign dictCode  = hitNarrow[CODE_W-1:0];

  // storage arrays
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          for (int k = 0; k < LINE_WORDS; k++) begin
            narrowMem[s][w][k] <= '0;
            wideMem[s][w][k]   <= '0;
          end
    end else if (strobe.writeCode) begin
      narrowMem[reqSet][reqHitWay][reqWord] <= {1'b1, wrCode};
    end else if (strobe.writeFull) begin
      narrowMem[reqSet][reqHitWay][reqWord] <= {1'b0, wrData[CODE_W-1:0]};
      wideMem[reqSet][reqHitWay][reqWord]   <= wrData[DATA_W-1:CODE_W];
    end
  end

  // pending word held across the second cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSet  <= '0;
      pendWord <= '0;
      pendCode <= '0;
    end else if (strobe.captureWide) begin
      pendSet  <= reqSet;
      pendWord <= reqWord;
      pendCode <= dictCode;
    end
  end

  // output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.loadDecoded | strobe.loadDirect | strobe.loadPending;
      if (strobe.loadDecoded)      rdData <= dictValue;
      else if (strobe.loadDirect)  rdData <= {hitWide, dictCode};
      else if (strobe.loadPending) rdData <= {pendWide, pendCode};
    end
  end
endmodule

// File: rtl/sbWordArray.sv
module sbWordArray
  import sbWordPkg::*;
#(
  parameter int NUM_WAYS     = 2,
  parameter int NUM_SETS     = 4,
  parameter int LINE_WORDS   = 4,
  parameter int DICT_ENTRIES = 16,
  localparam int CODE_W = $clog2(DICT_ENTRIES),
  localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WORD_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                compEn,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [SET_W-1:0]    reqSet,
  input  logic [WORD_W-1:0]   reqWord,
  input  logic                reqHit,
  input  logic [WAY_W-1:0]    reqHitWay,
  input  logic                wrCompressed,
  input  logic [CODE_W-1:0]   wrCode,
  input  logic [31:0]         wrData,
  output logic [CODE_W-1:0]   dictCode,
  input  logic [31:0]         dictValue,
  output logic                busy,
  output logic                rdValid,
  output logic [31:0]         rdData,
  output logic [NUM_WAYS-1:0] narrowEn,
  output logic [NUM_WAYS-1:0] wideEn
);
  sbStrobe_t        strobe;
  logic             hitFlag;
  logic [WAY_W-1:0] pendWay;

  sbCtrl #(.NUM_WAYS(NUM_WAYS)) uCtrl (
    .clk(clk), .rstN(rstN), .compEn(compEn), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqHit(reqHit), .reqHitWay(reqHitWay),
    .wrCompressed(wrCompressed), .hitFlag(hitFlag), .strobe(strobe),
    .busy(busy), .pendWay(pendWay), .narrowEn(narrowEn), .wideEn(wideEn)
  );

  sbDatapath #(
    .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS),
    .LINE_WORDS(LINE_WORDS), .DICT_ENTRIES(DICT_ENTRIES)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqSet(reqSet),
    .reqWord(reqWord), .reqHitWay(reqHitWay), .pendWay(pendWay),
    .wrCode(wrCode), .wrData(wrData), .dictValue(dictValue),
    .dictCode(dictCode), .hitFlag(hitFlag), .rdValid(rdValid),
    .rdData(rdData)
  );
endmodule

// File: rtl/sbWordArray_chk.sv
module sbWordArray_chk #(
  parameter int NUM_WAYS = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                compEn,
  input logic                reqValid,
  input logic                reqWrite,
  input logic                reqHit,
  input logic                busy,
  input logic                rdValid,
  input logic [NUM_WAYS-1:0] narrowEn,
  input logic [NUM_WAYS-1:0] wideEn
);
  logic accept;
  assign accept = reqValid && !busy;

  a_r5_miss_no_wide: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !reqWrite && !reqHit && compEn) |=> (!busy && wideEn == '0 && !rdValid));

  a_r4_single_wide_way: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(wideEn) == 1 && narrowEn == '0));

  a_r4_data_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (rdValid && !busy));

  a_r9_busy_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  a_r11_write_no_data: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqWrite) |=> !rdValid);

  a_r3_hit_response: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !reqWrite && reqHit && compEn) |=> (rdValid != busy));

  a_r7_write_miss_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqWrite && !reqHit) |-> (narrowEn == '0 && wideEn == '0));

  a_r8_off_all_banks: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !reqWrite && !compEn) |-> (&narrowEn && &wideEn));
endmodule

bind sbWordArray sbWordArray_chk #(.NUM_WAYS(NUM_WAYS)) uChk (
  .clk(clk), .rstN(rstN), .compEn(compEn), .reqValid(reqValid),
  .reqWrite(reqWrite), .reqHit(reqHit), .busy(busy), .rdValid(rdValid),
  .narrowEn(narrowEn), .wideEn(wideEn)
);

// File: tb/sbWordArray_test.sv
`timescale 1ns/1ps
module sbWordArray_test;
  localparam int WAYS = 2, SETS = 4, WORDS = 4, CW = 4;

  logic clk = 0, rstN = 0, compEn = 1, reqValid = 0, reqWrite = 0;
  logic [1:0] reqSet = 0, reqWord = 0;
  logic reqHit = 0, reqHitWay = 0, wrCompressed = 0;
  logic [CW-1:0] wrCode = 0, dictCode;
  logic [31:0] wrData = 0, dictValue, rdData;
  logic busy, rdValid;
  logic [WAYS-1:0] narrowEn, wideEn;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit mFlag [SETS][WAYS][WORDS];
  logic [CW-1:0] mCode [SETS][WAYS][WORDS];
  logic [31-CW:0] mWide [SETS][WAYS][WORDS];
  logic [31:0] expQ[$];
  int dueQ[$];
  string tagQ[$];

  function automatic logic [31:0] dictFn(input logic [CW-1:0] c);
    return 32'hF00D0001 + 32'(c) * 32'h00010111;
  endfunction
  assign dictValue = dictFn(dictCode);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sbWordArray uut (.*);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // monitor: pops expected reads
  always @(negedge clk) if (rstN && rdValid) begin
    if (expQ.size() == 0) chk(0, "R11 unexpected rdValid", rdData, 0);
    else begin
      logic [31:0] e; int d; string t;
      e = expQ.pop_front(); d = dueQ.pop_front(); t = tagQ.pop_front();
      chk(rdData == e, {t, " data"}, rdData, e);
      chk(cyc == d, {t, " latency"}, 32'(cyc), 32'(d));
    end
  end

  task automatic rdReq(input int s, w, way, input bit hit, input bit junk, input string rq);
    bit comp, two; logic [31:0] exp;
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqSet = 2'(s); reqWord = 2'(w);
    reqHit = hit; reqHitWay = 1'(way);
    #1;
    comp = compEn && mFlag[s][way][w];
    exp = comp ? dictFn(mCode[s][way][w]) : {mWide[s][way][w], mCode[s][way][w]};
    two = compEn && hit && !comp;
    chk(narrowEn == '1, {rq, " narrowEn"}, 32'(narrowEn), 32'h3);
    chk(wideEn == (compEn ? 2'b00 : 2'b11), {rq, " wideEn c1"}, 32'(wideEn), compEn ? 0 : 3);
    if (hit && comp) chk(dictCode == mCode[s][way][w], {rq, " dictCode"}, 32'(dictCode), 32'(mCode[s][way][w]));
    if (hit) begin expQ.push_back(exp); dueQ.push_back(cyc + (two ? 2 : 1)); tagQ.push_back(rq); end
    @(negedge clk);
    if (junk) begin  // R9: request during busy must be ignored
      reqWrite = 1; reqSet = 3; reqWord = 0; reqHitWay = 0; reqHit = 1;
      wrCompressed = 1; wrCode = 4'h7;
    end else reqValid = 0;
    #1;
    chk(busy == two, {rq, " busy"}, 32'(busy), 32'(two));
    chk(wideEn == (two ? 2'(1 << way) : 2'b00), {rq, " wideEn c2"}, 32'(wideEn), two ? (1 << way) : 0);
    if (two) begin
      chk(narrowEn == 0, "R9 narrowEn during busy", 32'(narrowEn), 0);
      @(negedge clk); reqValid = 0; reqWrite = 0; wrCompressed = 0;
    end
  endtask

  task automatic wrReq(input int s, w, way, input bit hit, comp, input logic [CW-1:0] code,
                       input logic [31:0] data, input string rq);
    logic [1:0] expN, expW;
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqSet = 2'(s); reqWord = 2'(w); reqHit = hit;
    reqHitWay = 1'(way); wrCompressed = comp; wrCode = code; wrData = data;
    #1;
    expN = hit ? 2'(1 << way) : 2'b00;
    expW = (hit && !(comp && compEn)) ? 2'(1 << way) : 2'b00;
    chk(narrowEn == expN, {rq, " narrowEn"}, 32'(narrowEn), 32'(expN));
    chk(wideEn == expW, {rq, " wideEn"}, 32'(wideEn), 32'(expW));
    if (hit) begin
      if (comp && compEn) begin mFlag[s][way][w] = 1; mCode[s][way][w] = code; end
      else begin
        mFlag[s][way][w] = 0; mCode[s][way][w] = data[CW-1:0]; mWide[s][way][w] = data[31:CW];
      end
    end
    @(negedge clk); reqValid = 0; reqWrite = 0; wrCompressed = 0;
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    foreach (mFlag[s, w, k]) begin mFlag[s][w][k] = 0; mCode[s][w][k] = 0; mWide[s][w][k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk(!busy && !rdValid, "R1 busy/rdValid", {busy, rdValid}, 0);
    chk(narrowEn == 0 && wideEn == 0, "R1 enables", {narrowEn, wideEn}, 0);
    rdReq(0, 1, 1, 1, 0, "R1 reset word");
    // R2 full write, R4 two-cycle read
    wrReq(1, 2, 0, 1, 0, 0, 32'h12345678, "R2 full write");
    rdReq(1, 2, 0, 1, 0, "R4 uncompressed hit");
    // R6 compressed write, R3 compressed read
    wrReq(1, 2, 1, 1, 1, 4'h5, 32'h0, "R6 code write");
    rdReq(1, 2, 1, 1, 0, "R3 compressed hit");
    rdReq(1, 2, 1, 0, 0, "R5 read miss");
    // R10 critical word among uncompressed neighbours
    wrReq(2, 0, 1, 1, 0, 0, 32'hAAAA5550, "R10 fill w0");
    wrReq(2, 1, 1, 1, 1, 4'h9, 32'h0, "R10 fill w1");
    wrReq(2, 2, 1, 1, 0, 0, 32'hBBBB0002, "R10 fill w2");
    rdReq(2, 1, 1, 1, 0, "R10 critical compressed");
    rdReq(2, 2, 1, 1, 0, "R10 neighbour uncompressed");
    // R9 request during busy ignored
    rdReq(0, 3, 0, 1, 1, "R9 busy read");
    rdReq(3, 0, 0, 1, 0, "R9 untouched word");
    // R7 write miss
    wrReq(1, 2, 0, 0, 0, 0, 32'hFFFFFFFF, "R7 write miss");
    rdReq(1, 2, 0, 1, 0, "R7 word unchanged");
    // R2 full write clears flag
    wrReq(2, 1, 1, 1, 0, 0, 32'h0BADF00D, "R2 overwrite");
    rdReq(2, 1, 1, 1, 0, "R2 flag cleared");
    // R8 compression off
    compEn = 0;
    rdReq(1, 2, 1, 1, 0, "R8 raw read");
    rdReq(1, 2, 1, 0, 0, "R8 miss");
    wrReq(0, 3, 0, 1, 1, 4'h3, 32'hCAFEBABE, "R8 write full");
    compEn = 1;
    rdReq(0, 3, 0, 1, 0, "R8 stored uncompressed");
    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R11 missing rdValid", 32'(expQ.size()), 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule